// File: doc/BRIEF.md
# Self-Checking GF(2^m) Polynomial Basis Multiplier

This block multiplies two elements of GF(2^m) in polynomial basis, modulo an irreducible polynomial whose coefficients are supplied at run time. It is meant for cryptographic datapaths, where a wrong product can leak key material. Every product is therefore formed twice, on two different arrays. The first pass uses the ordinary m-coefficient basis. The second pass uses operands shifted up by one basis position, so they live in an (m+1)-coefficient representation whose top coefficients are zero. The second result is folded back into the ordinary basis and compared with the stored first result. Any difference raises an error flag.

Each array also checks the reduction feedback line that it broadcasts between columns. The value seen by the consumers is compared with the value at the driver, so a fault on that global line is caught even when it does not alter the product. A test-only port can flip one chosen cell output or one feedback line during either pass. The caller pulses `start` with the operands. After two passes and a comparison cycle, the block presents the product and the flag together with a one-cycle `done`.

Top module: `gf2m_reso_mul`

## Requirements
- R1: When `done` is high, `prod` equals op_a·op_b reduced modulo x^M + poly·x + 1, where bit k of each operand and of `prod` is the coefficient of x^k and `poly[k]` is the coefficient of x^k for 1 ≤ k ≤ M−1. The constant term of the modulus is always 1.
- R2: A start accepted at clock edge n gives `done` high for exactly one cycle, between edges n+3 and n+4. `busy` is high from edge n until edge n+4.
- R3: `start` is accepted only while `busy` is low. A start pulse while busy, and any change of op_a, op_b or poly after acceptance, have no effect on the pending result.
- R4: With `flt_en` low throughout an operation, `err` is 0 at `done`, including right after an operation that reported an error.
- R5: A partial-product fault (`flt_kind`=0) flips the AND term of coefficient row `flt_row` and operand column `flt_col`. During the second pass (`flt_pass`=1, row 0..M), it gives `err`=1 and `prod` still equals the true product. During the first pass (`flt_pass`=0, row 0..M−1), it gives `err`=1.
- R6: A feedback-line fault (`flt_kind`=1) on column `flt_col` in either pass gives `err`=1.
- R7: A first-pass partial-product fault that names row M (a cell present only in the shifted array) has no effect: `err`=0 and `prod` is correct.
- R8: After reset, `busy`, `done` and `err` are 0 and `prod` is 0.
- R9: `prod` and `err` hold their values while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication (accepted when idle) |
| op_a | input | M | Multiplicand coefficients |
| op_b | input | M | Multiplier coefficients |
| poly | input | M−1 | Modulus coefficients x^1..x^(M−1) |
| flt_en | input | 1 | Test: enable fault injection |
| flt_pass | input | 1 | Test: 0 first pass, 1 second pass |
| flt_kind | input | 1 | Test: 0 partial-product cell, 1 feedback line |
| flt_row | input | ROW_W | Test: coefficient row of the faulted cell |
| flt_col | input | COL_W | Test: operand column of the faulted cell or line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| prod | output | M | Product in polynomial basis |
| err | output | 1 | Mismatch or feedback-line fault seen in the last operation |

## Verification
Products are checked with a fixed modulus against known field identities: multiplicative inverses, multiplication by x, and multiplication by zero and one. Further products use other moduli and pseudo-random operands, which separates a wrong reduction step from a wrong partial-product sum. Faults are swept over every cell and every feedback line in both passes. This shows that each single fault is flagged, that a second-pass fault leaves the reported product intact, and that a row existing only in the shifted array is harmless in the first pass. Clean operations placed after faulty ones show that the flag does not stick, and start pulses while busy show that the captured operands are kept.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PASS1 = 3'd1,
    ST_PASS2 = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4
  } gfc_state_e;

  typedef enum logic {
    FK_CELL = 1'b0,
    FK_LINE = 1'b1
  } gfc_fkind_e;
endpackage

// File: rtl/gfc_pb_array.sv
// Ordinary-basis array: column j holds x^j * B mod P, partial products a_j*col_j.
module gfc_pb_array #(
  parameter int M = 8
) (
  input  logic [M-1:0]   a,
  input  logic [M-1:0]   b,
  input  logic [M-1:1]   p_hi,
  input  logic [M*M-1:0] cell_flip,
  input  logic [M-1:0]   line_flip,
  output logic [M-1:0]   c,
  output logic           line_err
);
  logic [M-1:0] col [M];
  logic [M-1:0] fb_src;
  logic [M-1:0] fb_rx;
  logic [M*M-1:0] pp;

  assign col[0] = b;

  genvar j, i;
  generate
    for (j = 0; j < M; j++) begin : g_col
      assign fb_src[j] = col[j][M-1];
      assign fb_rx[j]  = fb_src[j] ^ line_flip[j];
      if (j < M-1) begin : g_next
        assign col[j+1] = {col[j][M-2:0] ^ (p_hi & {(M-1){fb_rx[j]}}), fb_rx[j]};
      end
      for (i = 0; i < M; i++) begin : g_pp
        assign pp[i*M+j] = (a[j] & col[j][i]) ^ cell_flip[i*M+j];
      end
    end
    for (i = 0; i < M; i++) begin : g_sum
      assign c[i] = ^pp[i*M +: M];
    end
  endgenerate

  // extra check column: driver of each broadcast line versus its far end
  assign line_err = |(fb_src ^ fb_rx);
endmodule

// File: rtl/gfc_spb_array.sv
// Shifted-basis array with M+1 rows; the row for the always-zero a_M is omitted.
module gfc_spb_array #(
  parameter int M = 8,
  localparam int N = M + 1
) (
  input  logic [M-1:0]   a,
  input  logic [M-1:0]   b,
  input  logic [M-1:0]   p_ext,
  input  logic [N*M-1:0] cell_flip,
  input  logic [M-1:0]   line_flip,
  output logic [N-1:0]   cbar,
  output logic           line_err
);
  logic [N-1:0] col [M];
  logic [M-1:0] fb_src;
  logic [M-1:0] fb_rx;
  logic [N*M-1:0] pp;

  assign col[0] = {1'b0, b};

  genvar j, i;
  generate
    for (j = 0; j < M; j++) begin : g_col
      assign fb_src[j] = col[j][M];
      assign fb_rx[j]  = fb_src[j] ^ line_flip[j];
      if (j < M-1) begin : g_next
        assign col[j+1] = {col[j][M-1:0] ^ (p_ext & {M{fb_rx[j]}}), 1'b0};
      end
      for (i = 0; i < N; i++) begin : g_pp
        assign pp[i*M+j] = (a[j] & col[j][i]) ^ cell_flip[i*M+j];
      end
    end
    for (i = 0; i < N; i++) begin : g_sum
      assign cbar[i] = ^pp[i*M +: M];
    end
  endgenerate

  assign line_err = |(fb_src ^ fb_rx);
endmodule

// File: rtl/gfc_fault_sel.sv
// Decodes the test-only fault selection into per-cell and per-line flip masks.
module gfc_fault_sel #(
  parameter int M     = 8,
  parameter int ROW_W = $clog2(M+1),
  parameter int COL_W = $clog2(M),
  localparam int N    = M + 1
) (
  input  logic             en,
  input  logic             sel_pass,
  input  logic             kind,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             in_pass1,
  input  logic             in_pass2,
  output logic [M*M-1:0]   cell1,
  output logic [N*M-1:0]   cell2,
  output logic [M-1:0]     line1,
  output logic [M-1:0]     line2
);
  import gfc_pkg::*;

  logic act1, act2, is_cell, is_line;
  assign act1    = en && in_pass1 && (sel_pass == 1'b0);
  assign act2    = en && in_pass2 && (sel_pass == 1'b1);
  assign is_cell = (kind == FK_CELL);
  assign is_line = (kind == FK_LINE);

  genvar i, j;
  generate
    for (j = 0; j < M; j++) begin : g_c
      assign line1[j] = act1 && is_line && (col == COL_W'(j));
      assign line2[j] = act2 && is_line && (col == COL_W'(j));
      for (i = 0; i < N; i++) begin : g_r
        if (i < M) begin : g_p1
          assign cell1[i*M+j] = act1 && is_cell && (row == ROW_W'(i)) && (col == COL_W'(j));
        end
        assign cell2[i*M+j] = act2 && is_cell && (row == ROW_W'(i)) && (col == COL_W'(j));
      end
    end
  endgenerate
endmodule

// File: rtl/gf2m_reso_mul.sv
module gf2m_reso_mul #(
  parameter int M     = 8,
  parameter int ROW_W = $clog2(M+1),
  parameter int COL_W = $clog2(M)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [M-1:0]     op_a,
  input  logic [M-1:0]     op_b,
  input  logic [M-1:1]     poly,
  input  logic             flt_en,
  input  logic             flt_pass,
  input  logic             flt_kind,
  input  logic [ROW_W-1:0] flt_row,
  input  logic [COL_W-1:0] flt_col,
  output logic             busy,
  output logic             done,
  output logic [M-1:0]     prod,
  output logic             err
);
  import gfc_pkg::*;

  localparam int N = M + 1;

  // fold a shifted-basis result back: x^M contributes the modulus tail
  function automatic logic [M-1:0] fold_back(input logic [N-1:0] cb, input logic [M-1:0] pe);
    return cb[M-1:0] ^ (pe & {M{cb[M]}});
  endfunction

  gfc_state_e state;
  logic [M-1:0] a_q, b_q, r1_q, r2_q, prod_q;
  logic [M-1:1] p_q;
  logic         line_hit, inj_seen, err_q;

  logic accept, in_pass1, in_pass2, cmp_mismatch, inj_now;
  logic [M-1:0]   c_pb, c_conv, p_ext;
  logic [N-1:0]   cbar;
  logic           line_err1, line_err2;
  logic [M*M-1:0] cell1;
  logic [N*M-1:0] cell2;
  logic [M-1:0]   line1, line2;

  assign accept   = start && (state == ST_IDLE);
  assign in_pass1 = (state == ST_PASS1);
  assign in_pass2 = (state == ST_PASS2);
  assign p_ext    = {p_q, 1'b1};

  gfc_fault_sel #(.M(M), .ROW_W(ROW_W), .COL_W(COL_W)) u_fsel (
    .en(flt_en), .sel_pass(flt_pass), .kind(flt_kind), .row(flt_row), .col(flt_col),
    .in_pass1(in_pass1), .in_pass2(in_pass2),
    .cell1(cell1), .cell2(cell2), .line1(line1), .line2(line2)
  );

  gfc_pb_array #(.M(M)) u_pb (
    .a(a_q), .b(b_q), .p_hi(p_q), .cell_flip(cell1), .line_flip(line1),
    .c(c_pb), .line_err(line_err1)
  );

  gfc_spb_array #(.M(M)) u_spb (
    .a(a_q), .b(b_q), .p_ext(p_ext), .cell_flip(cell2), .line_flip(line2),
    .cbar(cbar), .line_err(line_err2)
  );

  assign c_conv       = fold_back(cbar, p_ext);
  assign cmp_mismatch = (r1_q != r2_q);
  assign inj_now      = |{cell1, cell2, line1, line2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      p_q      <= '0;
      r1_q     <= '0;
      r2_q     <= '0;
      prod_q   <= '0;
      err_q    <= 1'b0;
      line_hit <= 1'b0;
      inj_seen <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          a_q      <= op_a;
          b_q      <= op_b;
          p_q      <= poly;
          line_hit <= 1'b0;
          inj_seen <= 1'b0;
          state    <= ST_PASS1;
        end
        ST_PASS1: begin
          r1_q     <= c_pb;
          line_hit <= line_hit | line_err1;
          inj_seen <= inj_seen | inj_now;
          state    <= ST_PASS2;
        end
        ST_PASS2: begin
          r2_q     <= c_conv;
          line_hit <= line_hit | line_err2;
          inj_seen <= inj_seen | inj_now;
          state    <= ST_CHECK;
        end
        ST_CHECK: begin
          prod_q <= r1_q;
          err_q  <= cmp_mismatch | line_hit;
          state  <= ST_DONE;
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign prod = prod_q;
  assign err  = err_q;
endmodule

// File: rtl/gfc_chk.sv
module gfc_chk #(
  parameter int M = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic [M-1:0] prod,
  input logic         accept,
  input logic         inj_seen
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##4 done);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_done_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_start_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_clean_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !inj_seen) |-> !err);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(prod) && $stable(err)));
endmodule

bind gf2m_reso_mul gfc_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .prod(prod), .accept(accept), .inj_seen(inj_seen)
);

// File: tb/gf2m_reso_mul_tb.sv
`timescale 1ns/1ps
module gf2m_reso_mul_tb;
  localparam int M  = 8;
  localparam int RW = $clog2(M+1);
  localparam int CW = $clog2(M);
  localparam logic [M-1:1] AES_P = 7'h0D;   // x^8+x^4+x^3+x+1

  // {a, b, expected} for the fixed modulus
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    24'h57_83_C1, 24'h57_13_FE, 24'h53_CA_01, 24'h02_87_15,
    24'hFF_01_FF, 24'h00_A5_00, 24'h01_01_01
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [M-1:0] op_a = '0, op_b = '0;
  logic [M-1:1] poly = '0;
  logic flt_en = 1'b0, flt_pass = 1'b0, flt_kind = 1'b0;
  logic [RW-1:0] flt_row = '0;
  logic [CW-1:0] flt_col = '0;
  logic busy, done, err;
  logic [M-1:0] prod;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gf2m_reso_mul #(.M(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b), .poly(poly),
    .flt_en(flt_en), .flt_pass(flt_pass), .flt_kind(flt_kind), .flt_row(flt_row),
    .flt_col(flt_col), .busy(busy), .done(done), .prod(prod), .err(err)
  );

  // schoolbook product then long division by the full modulus
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b,
                                           input logic [M-1:1] p);
    logic [2*M-2:0] acc = '0;
    logic [M:0] md = {1'b1, p, 1'b1};
    for (int i = 0; i < M; i++) if (b[i]) acc ^= (2*M-1)'(a) << i;
    for (int k = 2*M-2; k >= M; k--) if (acc[k]) acc ^= (2*M-1)'(md) << (k-M);
    return acc[M-1:0];
  endfunction

  task automatic chk(input string tag, input logic [M-1:0] got, input logic [M-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b, input logic [M-1:1] p,
                        input logic fen, input logic fps, input logic fkd,
                        input int frow, input int fcol,
                        output logic [M-1:0] gp, output logic ge, output logic gd);
    @(negedge clk);
    op_a = a; op_b = b; poly = p;
    flt_en = fen; flt_pass = fps; flt_kind = fkd;
    flt_row = RW'(frow); flt_col = CW'(fcol);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    gp = prod; ge = err; gd = done;
    flt_en = 1'b0;
    @(negedge clk);
  endtask

  logic [M-1:0] gp;
  logic ge, gd;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 busy", {7'b0, busy}, 8'h00);
    chk("R8 done", {7'b0, done}, 8'h00);
    chk("R8 err", {7'b0, err}, 8'h00);
    chk("R8 prod", prod, 8'h00);
    rst_n = 1'b1;

    // R1 table with the fixed modulus
    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][23:16], VEC[v][15:8], AES_P, 0, 0, 0, 0, 0, gp, ge, gd);
      chk("R1 table prod", gp, VEC[v][7:0]);
      chk("R2 done", {7'b0, gd}, 8'h01);
      chk("R4 clean err", {7'b0, ge}, 8'h00);
    end

    // R2 latency and single-cycle strobe
    @(negedge clk);
    op_a = 8'h57; op_b = 8'h83; poly = AES_P; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after accept", {7'b0, busy}, 8'h01);
    chk("R2 no early done", {7'b0, done}, 8'h00);
    @(negedge clk);
    chk("R2 no done at n+2", {7'b0, done}, 8'h00);
    @(negedge clk);
    chk("R2 no done at n+3", {7'b0, done}, 8'h00);
    @(negedge clk);
    chk("R2 done at n+4", {7'b0, done}, 8'h01);
    @(negedge clk);
    chk("R2 done falls", {7'b0, done}, 8'h00);
    chk("R2 busy falls", {7'b0, busy}, 8'h00);
    // R9 hold while idle
    op_a = 8'hFF; op_b = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R9 prod held", prod, 8'hC1);
    chk("R9 err held", {7'b0, err}, 8'h00);

    // R3 start and operand changes while busy
    @(negedge clk);
    op_a = 8'h02; op_b = 8'h87; poly = AES_P; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; op_a = 8'h33;
    @(negedge clk);
    start = 1'b1; op_b = 8'h44; poly = 7'h7F;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R3 result kept", prod, 8'h15);
    chk("R3 done", {7'b0, done}, 8'h01);
    @(negedge clk);
    chk("R3 no second op", {7'b0, busy}, 8'h00);

    // R1 other moduli, pseudo-random operands
    for (int t = 0; t < 40; t++) begin
      logic [M-1:1] pp;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      pp = (t % 2 == 0) ? 7'h16 : 7'h31;    // x^8+x^5+x^3+x^2+1, x^8+x^6+x^5+x+1
      run_op(lfsr[7:0], lfsr[15:8], pp, 0, 0, 0, 0, 0, gp, ge, gd);
      chk("R1 random prod", gp, ref_mul(lfsr[7:0], lfsr[15:8], pp));
      chk("R4 random err", {7'b0, ge}, 8'h00);
    end

    // R5 second-pass cell faults: every row 0..M, every column
    for (int r = 0; r <= M; r++) begin
      for (int c = 0; c < M; c++) begin
        run_op(8'hB6, 8'h5D, AES_P, 1, 1, 0, r, c, gp, ge, gd);
        chk("R5 pass2 cell err", {7'b0, ge}, 8'h01);
        chk("R5 pass2 prod intact", gp, ref_mul(8'hB6, 8'h5D, AES_P));
      end
    end
    // R5 first-pass cell faults, rows 0..M-1
    for (int r = 0; r < M; r++) begin
      for (int c = 0; c < M; c++) begin
        run_op(8'h00, 8'h00, AES_P, 1, 0, 0, r, c, gp, ge, gd);
        chk("R5 pass1 cell err", {7'b0, ge}, 8'h01);
      end
    end
    // R4 clean op right after a faulty one
    run_op(8'h57, 8'h13, AES_P, 0, 0, 0, 0, 0, gp, ge, gd);
    chk("R4 err cleared", {7'b0, ge}, 8'h00);
    chk("R4 prod after fault", gp, 8'hFE);

    // R6 feedback-line faults in both passes
    for (int c = 0; c < M; c++) begin
      run_op(8'h80, 8'h80, AES_P, 1, 0, 1, 0, c, gp, ge, gd);
      chk("R6 pass1 line err", {7'b0, ge}, 8'h01);
      run_op(8'h80, 8'h80, AES_P, 1, 1, 1, 0, c, gp, ge, gd);
      chk("R6 pass2 line err", {7'b0, ge}, 8'h01);
    end

    // R7 first-pass fault naming row M is harmless
    for (int c = 0; c < M; c++) begin
      run_op(8'hC3, 8'h9A, AES_P, 1, 0, 0, M, c, gp, ge, gd);
      chk("R7 row M err", {7'b0, ge}, 8'h00);
      chk("R7 row M prod", gp, ref_mul(8'hC3, 8'h9A, AES_P));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule